// File: doc/BRIEF.md
# Store-to-Load Forwarding Lookup

This block decides what happens to a load that is about to execute. It looks at the stores that are older than the load and still sit in the store queue, and picks one of four outcomes. If the nearest overlapping store covers every byte of the load, the data comes straight from that store. If the nearest overlapping store covers only part of the load, the load is sent back for replay. If no store overlaps, a memory read is issued. An uncacheable load that is not yet safe to perform is refused before any search. The block also remembers two things: the oldest load that was stalled by a partial overlap, and the oldest load that met a blocked cache. Each of these is kept until the surrounding pipeline releases it.

Loads enter through a valid/ready stream. A load is accepted on a rising clock edge when `ld_valid` and `ld_ready` are both high. Its outcome appears on the result stream one cycle later. A result stays on the result stream, unchanged, until `out_ready` is high. `ld_ready` is high whenever the result register is empty or is being drained in the same cycle. The store queue contents, the writeback pointer and the cache-blocked flag are plain inputs, and they are sampled in the acceptance cycle. `SQ_DEPTH` must be a power of two. Sizes are coded as log2 of the byte count, so 0 means 1 byte, 1 means 2, 2 means 4 and 3 means 8. Data is little-endian: byte n of a value is bits [8n+7:8n]. Sequence numbers are compared as plain unsigned values, and a smaller number means an older instruction.

Top module: `fwd_lookup_unit`

## Requirements
- R1: The search examines the store entries `ld_sq_pos-1`, `ld_sq_pos-2`, and so on, wrapping modulo `SQ_DEPTH`. It ends with `sq_wb_ptr`, which is included. When `ld_sq_pos` equals `sq_wb_ptr`, no entry is examined. Entries outside this window have no effect.
- R2: Among the examined entries that overlap the load, the one closest to `ld_sq_pos` (the youngest) alone decides the outcome.
- R3: An entry whose `sq_filled` bit is 0, or whose `sq_uncached` bit is 1, is skipped.
- R4: A store with start S and byte count B fully contains a load with start A and byte count L when A ≥ S and A+L ≤ S+B. In that case `out_kind` is 0 (forward). `out_data` holds the store data shifted right by (A AND (B-1)) bytes, with only the low L bytes kept and the upper bytes zero.
- R5: When the byte ranges intersect but the load is not fully contained, `out_kind` is 1 (partial replay) and `out_data` is zero.
- R6: A partial replay records the store's sequence number, the load's queue index and the load's sequence number into the stall state. This happens when the stall state is empty, or when the new load's sequence number is smaller than the recorded one. The stall state then holds until a `stall_release` pulse clears it.
- R7: A load with `ld_uncached`=1 is refused unless both `ld_at_head` and `ld_commit_ok` are 1. A refused load gets `out_kind` 3 and zero data, and it neither searches nor touches the stall state. A load that is allowed through is searched like any other load.
- R8: When no examined entry overlaps the load, `out_kind` is 2 (memory read) and `out_data` is zero.
- R9: A memory-read outcome while `cache_blocked`=1 records the load's sequence number as blocked. This is skipped when an older load (smaller sequence number) is already recorded. The record holds until a `blk_release` pulse clears it.
- R10: The result is valid in the cycle after acceptance. `out_seq` and `out_lq_idx` echo the load. While `out_valid`=1 and `out_ready`=0, the result holds steady and `ld_ready` is 0.
- R11: After reset, `out_valid`, `stall_valid` and `blk_valid` are 0 and `ld_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load request valid |
| ld_ready | output | 1 | Load request can be accepted |
| ld_addr | input | ADDR_W | Load start address |
| ld_size | input | 2 | Load size, log2 bytes |
| ld_seq | input | SEQ_W | Load sequence number |
| ld_lq_idx | input | LQ_IDX_W | Load queue index of the load |
| ld_sq_pos | input | SQ_IDX_W | Store-queue position recorded for the load |
| ld_uncached | input | 1 | Load targets uncacheable space |
| ld_at_head | input | 1 | Load is at the load-queue head |
| ld_commit_ok | input | 1 | Load is ready to commit |
| sq_wb_ptr | input | SQ_IDX_W | Oldest store not yet written back |
| sq_filled | input | SQ_DEPTH | Entry has address and data |
| sq_uncached | input | SQ_DEPTH | Entry is an uncacheable store |
| sq_addr | input | SQ_DEPTH x ADDR_W | Store start addresses |
| sq_size | input | SQ_DEPTH x 2 | Store sizes, log2 bytes |
| sq_data | input | SQ_DEPTH x 64 | Store data, little-endian |
| sq_seq | input | SQ_DEPTH x SEQ_W | Store sequence numbers |
| cache_blocked | input | 1 | Cache cannot take a read now |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumer ready |
| out_kind | output | 2 | 0 forward, 1 partial replay, 2 memory read, 3 uncached refusal |
| out_data | output | 64 | Forwarded data, zero otherwise |
| out_seq | output | SEQ_W | Sequence number of the load |
| out_lq_idx | output | LQ_IDX_W | Load queue index of the load |
| stall_valid | output | 1 | A partial-overlap stall is recorded |
| stall_store_seq | output | SEQ_W | Sequence number of the stalling store |
| stall_lq_idx | output | LQ_IDX_W | Load queue index of the stalled load |
| stall_release | input | 1 | Clears the stall record |
| blk_valid | output | 1 | A cache-blocked load is recorded |
| blk_seq | output | SEQ_W | Sequence number of the blocked load |
| blk_release | input | 1 | Clears the blocked record |

## Verification
A wrong search window or a wrong age priority shows up in `out_kind` or `out_data` one cycle after the load is accepted. Nothing else in the block carries that error forward. A wrong stall or blocked record shows on the `stall_*` and `blk_*` outputs in that same cycle. It stays wrong until the next release, so every later load compared against the bad record also gives a visibly wrong update. A hold fault on the result register shows during the first cycle of back-pressure.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    K_FWD  = 2'd0,
    K_PART = 2'd1,
    K_MEM  = 2'd2,
    K_UNC  = 2'd3
  } res_kind_e;

  localparam int DATA_W = 64;
endpackage

// File: rtl/fwd_range_cmp.sv
module fwd_range_cmp #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [1:0]        ld_size,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_size,
  input  logic              st_live,
  output logic              full_hit,
  output logic              any_hit
);
  localparam int EW = ADDR_W + 1;

  logic [EW-1:0] l_lo, l_hi, s_lo, s_hi;

  always_comb begin
    l_lo = {1'b0, ld_addr};
    s_lo = {1'b0, st_addr};
    l_hi = l_lo + (EW'(1) << ld_size);
    s_hi = s_lo + (EW'(1) << st_size);
    any_hit  = st_live && (l_lo < s_hi) && (l_hi > s_lo);
    full_hit = st_live && (l_lo >= s_lo) && (l_hi <= s_hi);
  end
endmodule

// File: rtl/fwd_age_pick.sv
module fwd_age_pick #(
  parameter int SQ_DEPTH = 8,
  localparam int IW = $clog2(SQ_DEPTH)
) (
  input  logic [SQ_DEPTH-1:0] hit,
  input  logic [IW-1:0]       start_pos,
  input  logic [IW-1:0]       stop_ptr,
  output logic                found,
  output logic [IW-1:0]       sel
);
  logic [IW-1:0] span;

  always_comb begin
    span  = start_pos - stop_ptr;
    found = 1'b0;
    sel   = '0;
    // walk oldest-to-youngest so the youngest hit is written last
    for (int k = SQ_DEPTH - 1; k >= 1; k--) begin
      if ((IW'(k) <= span) && hit[start_pos - IW'(k)]) begin
        found = 1'b1;
        sel   = start_pos - IW'(k);
      end
    end
  end
endmodule

// File: rtl/fwd_align.sv
module fwd_align (
  input  logic [63:0] st_data,
  input  logic [1:0]  st_size,
  input  logic [2:0]  ld_lsb,
  input  logic [1:0]  ld_size,
  output logic [63:0] ld_data
);
  logic [2:0]  off;
  logic [2:0]  smask;
  logic [63:0] shifted;

  always_comb begin
    smask   = 3'((4'd1 << st_size) - 4'd1);
    off     = ld_lsb & smask;
    shifted = st_data >> {off, 3'b000};
    unique case (ld_size)
      2'd0:    ld_data = {56'd0, shifted[7:0]};
      2'd1:    ld_data = {48'd0, shifted[15:0]};
      2'd2:    ld_data = {32'd0, shifted[31:0]};
      default: ld_data = shifted;
    endcase
  end
endmodule

// File: rtl/fwd_hazard_track.sv
module fwd_hazard_track #(
  parameter int SEQ_W    = 16,
  parameter int LQ_IDX_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rec_part,
  input  logic                rec_mem_blk,
  input  logic [SEQ_W-1:0]    ld_seq,
  input  logic [LQ_IDX_W-1:0] ld_lq_idx,
  input  logic [SEQ_W-1:0]    st_seq,
  input  logic                stall_release,
  input  logic                blk_release,
  output logic                stall_valid,
  output logic [SEQ_W-1:0]    stall_store_seq,
  output logic [LQ_IDX_W-1:0] stall_lq_idx,
  output logic                blk_valid,
  output logic [SEQ_W-1:0]    blk_seq
);
  logic [SEQ_W-1:0] stall_ld_seq;
  logic             stall_cur, blk_cur;
  logic             take_stall, take_blk;

  always_comb begin
    stall_cur  = stall_valid && !stall_release;
    blk_cur    = blk_valid && !blk_release;
    take_stall = rec_part && (!stall_cur || (ld_seq < stall_ld_seq));
    take_blk   = rec_mem_blk && !(blk_cur && (blk_seq < ld_seq));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stall_valid     <= 1'b0;
      stall_store_seq <= '0;
      stall_lq_idx    <= '0;
      stall_ld_seq    <= '0;
      blk_valid       <= 1'b0;
      blk_seq         <= '0;
    end else begin
      if (take_stall) begin
        stall_valid     <= 1'b1;
        stall_store_seq <= st_seq;
        stall_lq_idx    <= ld_lq_idx;
        stall_ld_seq    <= ld_seq;
      end else if (stall_release) begin
        stall_valid <= 1'b0;
      end
      if (take_blk) begin
        blk_valid <= 1'b1;
        blk_seq   <= ld_seq;
      end else if (blk_release) begin
        blk_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fwd_lookup_unit.sv
module fwd_lookup_unit
  import fwd_pkg::*;
#(
  parameter int SQ_DEPTH = 8,
  parameter int ADDR_W   = 16,
  parameter int SEQ_W    = 16,
  parameter int LQ_DEPTH = 16,
  localparam int SQ_IDX_W = $clog2(SQ_DEPTH),
  localparam int LQ_IDX_W = $clog2(LQ_DEPTH)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               ld_valid,
  output logic                               ld_ready,
  input  logic [ADDR_W-1:0]                  ld_addr,
  input  logic [1:0]                         ld_size,
  input  logic [SEQ_W-1:0]                   ld_seq,
  input  logic [LQ_IDX_W-1:0]                ld_lq_idx,
  input  logic [SQ_IDX_W-1:0]                ld_sq_pos,
  input  logic                               ld_uncached,
  input  logic                               ld_at_head,
  input  logic                               ld_commit_ok,
  input  logic [SQ_IDX_W-1:0]                sq_wb_ptr,
  input  logic [SQ_DEPTH-1:0]                sq_filled,
  input  logic [SQ_DEPTH-1:0]                sq_uncached,
  input  logic [SQ_DEPTH-1:0][ADDR_W-1:0]    sq_addr,
  input  logic [SQ_DEPTH-1:0][1:0]           sq_size,
  input  logic [SQ_DEPTH-1:0][DATA_W-1:0]    sq_data,
  input  logic [SQ_DEPTH-1:0][SEQ_W-1:0]     sq_seq,
  input  logic                               cache_blocked,
  output logic                               out_valid,
  input  logic                               out_ready,
  output logic [1:0]                         out_kind,
  output logic [DATA_W-1:0]                  out_data,
  output logic [SEQ_W-1:0]                   out_seq,
  output logic [LQ_IDX_W-1:0]                out_lq_idx,
  output logic                               stall_valid,
  output logic [SEQ_W-1:0]                   stall_store_seq,
  output logic [LQ_IDX_W-1:0]                stall_lq_idx,
  input  logic                               stall_release,
  output logic                               blk_valid,
  output logic [SEQ_W-1:0]                   blk_seq,
  input  logic                               blk_release
);
  logic [SQ_DEPTH-1:0] full_v, any_v;
  logic                found;
  logic [SQ_IDX_W-1:0] sel;
  logic [DATA_W-1:0]   fwd_data;
  logic                refuse, fire;
  res_kind_e           kind_nx;
  logic [DATA_W-1:0]   data_nx;

  for (genvar g = 0; g < SQ_DEPTH; g++) begin : g_cmp
    fwd_range_cmp #(.ADDR_W(ADDR_W)) cmp_i (
      .ld_addr (ld_addr),
      .ld_size (ld_size),
      .st_addr (sq_addr[g]),
      .st_size (sq_size[g]),
      .st_live (sq_filled[g] && !sq_uncached[g]),
      .full_hit(full_v[g]),
      .any_hit (any_v[g])
    );
  end

  fwd_age_pick #(.SQ_DEPTH(SQ_DEPTH)) pick_i (
    .hit      (any_v),
    .start_pos(ld_sq_pos),
    .stop_ptr (sq_wb_ptr),
    .found    (found),
    .sel      (sel)
  );

  fwd_align align_i (
    .st_data(sq_data[sel]),
    .st_size(sq_size[sel]),
    .ld_lsb (ld_addr[2:0]),
    .ld_size(ld_size),
    .ld_data(fwd_data)
  );

  always_comb begin
    ld_ready = !out_valid || out_ready;
    fire     = ld_valid && ld_ready;
    refuse   = ld_uncached && !(ld_at_head && ld_commit_ok);
    if (refuse)           kind_nx = K_UNC;
    else if (!found)      kind_nx = K_MEM;
    else if (full_v[sel]) kind_nx = K_FWD;
    else                  kind_nx = K_PART;
    data_nx = (kind_nx == K_FWD) ? fwd_data : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_kind   <= 2'd0;
      out_data   <= '0;
      out_seq    <= '0;
      out_lq_idx <= '0;
    end else if (fire) begin
      out_valid  <= 1'b1;
      out_kind   <= kind_nx;
      out_data   <= data_nx;
      out_seq    <= ld_seq;
      out_lq_idx <= ld_lq_idx;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  fwd_hazard_track #(.SEQ_W(SEQ_W), .LQ_IDX_W(LQ_IDX_W)) haz_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .rec_part       (fire && (kind_nx == K_PART)),
    .rec_mem_blk    (fire && (kind_nx == K_MEM) && cache_blocked),
    .ld_seq         (ld_seq),
    .ld_lq_idx      (ld_lq_idx),
    .st_seq         (sq_seq[sel]),
    .stall_release  (stall_release),
    .blk_release    (blk_release),
    .stall_valid    (stall_valid),
    .stall_store_seq(stall_store_seq),
    .stall_lq_idx   (stall_lq_idx),
    .blk_valid      (blk_valid),
    .blk_seq        (blk_seq)
  );
endmodule

// File: rtl/fwd_lookup_chk.sv
module fwd_lookup_chk #(
  parameter int SEQ_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld_valid,
  input logic             ld_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [1:0]       out_kind,
  input logic [63:0]      out_data,
  input logic [SEQ_W-1:0] out_seq,
  input logic             stall_valid,
  input logic             stall_release,
  input logic             blk_valid,
  input logic             blk_release,
  input logic             cache_blocked
);
  // R10
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) && $stable(out_data) && $stable(out_seq)));

  // R10
  result_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |=> out_valid);

  // R10
  no_accept_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !ld_ready);

  // R5
  data_only_on_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind != 2'd0) |-> (out_data == 64'd0));

  // R6
  stall_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_valid && !stall_release) |=> stall_valid);

  // R6
  stall_from_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_valid) |-> $past(ld_valid && ld_ready));

  // R9
  blk_from_cache_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk_valid) |-> $past(cache_blocked && ld_valid && ld_ready));

  // R9
  blk_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && !blk_release) |=> blk_valid);
endmodule

bind fwd_lookup_unit fwd_lookup_chk #(.SEQ_W(SEQ_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .ld_valid     (ld_valid),
  .ld_ready     (ld_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_kind     (out_kind),
  .out_data     (out_data),
  .out_seq      (out_seq),
  .stall_valid  (stall_valid),
  .stall_release(stall_release),
  .blk_valid    (blk_valid),
  .blk_release  (blk_release),
  .cache_blocked(cache_blocked)
);

// File: tb/fwd_lookup_unit_tb_top.sv
module fwd_lookup_unit_tb_top;
  localparam int N  = 8;
  localparam int AW = 16;
  localparam int SW = 16;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic ld_valid = 0, ld_ready;
  logic [AW-1:0] ld_addr = 0;
  logic [1:0] ld_size = 0;
  logic [SW-1:0] ld_seq = 0;
  logic [LW-1:0] ld_lq_idx = 0;
  logic [2:0] ld_sq_pos = 0;
  logic ld_uncached = 0, ld_at_head = 0, ld_commit_ok = 0;
  logic [2:0] sq_wb_ptr = 0;
  logic [N-1:0] sq_filled = 0, sq_uncached = 0;
  logic [N-1:0][AW-1:0] sq_addr = '0;
  logic [N-1:0][1:0] sq_size = '0;
  logic [N-1:0][63:0] sq_data = '0;
  logic [N-1:0][SW-1:0] sq_seq = '0;
  logic cache_blocked = 0;
  logic out_valid, out_ready = 1;
  logic [1:0] out_kind;
  logic [63:0] out_data;
  logic [SW-1:0] out_seq;
  logic [LW-1:0] out_lq_idx;
  logic stall_valid, blk_valid;
  logic [SW-1:0] stall_store_seq, blk_seq;
  logic [LW-1:0] stall_lq_idx;
  logic stall_release = 0, blk_release = 0;

  fwd_lookup_unit dut_i (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench-side reference state
  bit m_st_v = 0; int m_st_sseq = 0, m_st_lq = 0, m_st_lseq = 0;
  bit m_bk_v = 0; int m_bk_seq = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference outcome from the requirements
  function automatic void ref_out(output int k, output logic [63:0] d, output int sseq);
    int span, la, ls;
    k = 2; d = 64'd0; sseq = 0;
    if (ld_uncached && !(ld_at_head && ld_commit_ok)) begin k = 3; return; end
    span = (int'(ld_sq_pos) - int'(sq_wb_ptr)) & (N - 1);
    la = int'(ld_addr); ls = 1 << ld_size;
    for (int j = 1; j <= span; j++) begin
      int ix, sa, ss, off;
      ix = (int'(ld_sq_pos) - j) & (N - 1);
      if (!sq_filled[ix] || sq_uncached[ix]) continue;
      sa = int'(sq_addr[ix]); ss = 1 << sq_size[ix];
      if (la >= sa && la + ls <= sa + ss) begin
        off = la & (ss - 1);
        d = sq_data[ix] >> (off * 8);
        if (ls < 8) d = d & ((64'd1 << (ls * 8)) - 64'd1);
        k = 0; sseq = int'(sq_seq[ix]); return;
      end
      if (la < sa + ss && la + ls > sa) begin
        k = 1; sseq = int'(sq_seq[ix]); return;
      end
    end
  endfunction

  task automatic do_load(input int a, input int sz, input int sq, input int lq,
                         input int pos, input bit unc, input bit hd, input bit cok,
                         input string tag);
    int k, ss; logic [63:0] d;
    @(negedge clk);
    ld_addr = AW'(a); ld_size = 2'(sz); ld_seq = SW'(sq); ld_lq_idx = LW'(lq);
    ld_sq_pos = 3'(pos); ld_uncached = unc; ld_at_head = hd; ld_commit_ok = cok;
    ld_valid = 1;
    ref_out(k, d, ss);
    if (k == 1 && (!m_st_v || sq < m_st_lseq)) begin
      m_st_v = 1; m_st_sseq = ss; m_st_lq = lq; m_st_lseq = sq;
    end
    if (k == 2 && cache_blocked && !(m_bk_v && m_bk_seq < sq)) begin
      m_bk_v = 1; m_bk_seq = sq;
    end
    @(negedge clk);
    ld_valid = 0;
    chk(out_valid === 1'b1, "R10", "out_valid", 64'(out_valid), 1);
    chk(out_kind === 2'(k), tag, "out_kind", 64'(out_kind), 64'(k));
    chk(out_data === d, tag, "out_data", out_data, d);
    chk(out_seq === SW'(sq) && out_lq_idx === LW'(lq), "R10", "echo", 64'(out_seq), 64'(sq));
    chk(stall_valid === m_st_v, "R6", "stall_valid", 64'(stall_valid), 64'(m_st_v));
    if (m_st_v) begin
      chk(stall_store_seq === SW'(m_st_sseq), "R6", "stall_store_seq", 64'(stall_store_seq), 64'(m_st_sseq));
      chk(stall_lq_idx === LW'(m_st_lq), "R6", "stall_lq_idx", 64'(stall_lq_idx), 64'(m_st_lq));
    end
    chk(blk_valid === m_bk_v, "R9", "blk_valid", 64'(blk_valid), 64'(m_bk_v));
    if (m_bk_v) chk(blk_seq === SW'(m_bk_seq), "R9", "blk_seq", 64'(blk_seq), 64'(m_bk_seq));
  endtask

  task automatic rel_stall();
    @(negedge clk); stall_release = 1;
    @(negedge clk); stall_release = 0; m_st_v = 0;
    chk(stall_valid === 1'b0, "R6", "stall after release", 64'(stall_valid), 0);
  endtask

  task automatic rel_blk();
    @(negedge clk); blk_release = 1;
    @(negedge clk); blk_release = 0; m_bk_v = 0;
    chk(blk_valid === 1'b0, "R9", "blk after release", 64'(blk_valid), 0);
  endtask

  task automatic put_st(input int i, input int a, input int sz, input logic [63:0] d, input bit u);
    sq_filled[i] = 1; sq_uncached[i] = u; sq_addr[i] = AW'(a);
    sq_size[i] = 2'(sz); sq_data[i] = d;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) sq_seq[i] = SW'(100 + i);
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(out_valid === 0 && stall_valid === 0 && blk_valid === 0, "R11", "reset flags",
        {61'd0, out_valid, stall_valid, blk_valid}, 0);
    chk(ld_ready === 1'b1, "R11", "ld_ready in reset", 64'(ld_ready), 1);
    rst_n = 1;

    // R4: forward with byte offset, literal value
    put_st(3, 8, 3, 64'h1122334455667788, 0);
    do_load(10, 1, 10, 1, 4, 0, 0, 0, "R4");
    chk(out_data === 64'h5566, "R4", "literal fwd", out_data, 64'h5566);
    // R1: empty window
    do_load(10, 1, 11, 1, 0, 0, 0, 0, "R1");
    // R1: match only outside window
    sq_filled[3] = 0; put_st(1, 8, 3, 64'hAB, 0); sq_wb_ptr = 2;
    do_load(8, 0, 12, 1, 4, 0, 0, 0, "R1");
    chk(out_kind === 2'd2, "R1", "outside window kind", 64'(out_kind), 2);
    sq_wb_ptr = 0; sq_filled = 0;
    // R2: youngest wins
    put_st(2, 8, 3, 64'hCAFEF00D_12345678, 0);
    put_st(3, 8, 2, 64'h00000000_DEADBEEF, 0);
    do_load(8, 2, 13, 2, 4, 0, 0, 0, "R2");
    chk(out_data === 64'hDEADBEEF, "R2", "youngest data", out_data, 64'hDEADBEEF);
    // R3: uncached store skipped, then empty store skipped
    sq_uncached[3] = 1;
    do_load(8, 2, 14, 2, 4, 0, 0, 0, "R3");
    chk(out_data === 64'h12345678, "R3", "skip uncached", out_data, 64'h12345678);
    sq_uncached[3] = 0; sq_filled[3] = 0;
    do_load(8, 2, 15, 2, 4, 0, 0, 0, "R3");
    // R5/R6: partial overlap and stall ordering
    sq_filled = 0; put_st(3, 16, 2, 64'h1, 0);
    do_load(18, 2, 50, 5, 4, 0, 0, 0, "R5");
    do_load(18, 2, 60, 6, 4, 0, 0, 0, "R5");
    do_load(19, 0, 40, 7, 4, 0, 0, 0, "R4");
    do_load(17, 2, 40, 7, 4, 0, 0, 0, "R5");
    chk(stall_lq_idx === 4'd7, "R6", "older load recorded", 64'(stall_lq_idx), 7);
    rel_stall();
    // R7: uncached load refusal, then allowed
    do_load(18, 2, 70, 3, 4, 1, 0, 1, "R7");
    chk(stall_valid === 1'b0, "R7", "refusal no stall", 64'(stall_valid), 0);
    do_load(18, 2, 71, 3, 4, 1, 1, 0, "R7");
    do_load(18, 2, 72, 3, 4, 1, 1, 1, "R7");
    rel_stall();
    // R8/R9: memory read and blocked record
    sq_filled = 0; cache_blocked = 1;
    do_load(0, 3, 30, 1, 4, 0, 0, 0, "R8");
    do_load(0, 3, 35, 1, 4, 0, 0, 0, "R9");
    do_load(0, 3, 20, 1, 4, 0, 0, 0, "R9");
    chk(blk_seq === 16'd20, "R9", "older blocked kept", 64'(blk_seq), 20);
    rel_blk(); cache_blocked = 0;
    // R10: back-pressure
    put_st(3, 8, 3, 64'h77, 0);
    @(negedge clk); out_ready = 0;
    ld_addr = 8; ld_size = 0; ld_sq_pos = 4; ld_uncached = 0; ld_seq = 90; ld_valid = 1;
    @(negedge clk);
    ld_addr = 40; ld_seq = 91;
    chk(ld_ready === 1'b0, "R10", "ld_ready under stall", 64'(ld_ready), 0);
    @(negedge clk);
    chk(out_valid === 1 && out_seq === 16'd90 && out_data === 64'h77, "R10", "held result",
        out_data, 64'h77);
    ld_valid = 0; out_ready = 1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R10", "drained", 64'(out_valid), 0);

    // random phase
    for (int it = 0; it < 400; it++) begin
      if (it % 16 == 0) begin
        sq_wb_ptr = 3'($urandom % N);
        for (int i = 0; i < N; i++) begin
          int sz;
          sz = $urandom % 4;
          sq_filled[i] = ($urandom % 4) != 0;
          sq_uncached[i] = ($urandom % 8) == 0;
          sq_size[i] = 2'(sz);
          sq_addr[i] = AW'(($urandom % 32) & ~((1 << sz) - 1));
          sq_data[i] = {$urandom, $urandom};
        end
      end
      cache_blocked = ($urandom % 4) == 0;
      begin
        int rs, ra;
        rs = $urandom % 4;
        ra = ($urandom % 32) & ~((1 << rs) - 1);
        do_load(ra, rs, $urandom % 1000, $urandom % 16, $urandom % N,
                ($urandom % 8) == 0, $urandom % 2, $urandom % 2, "R4");
      end
      if ($urandom % 10 == 0) rel_stall();
      if ($urandom % 10 == 0) rel_blk();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule